// File: doc/BRIEF.md
# FIFO Flag Offset Load Sequencer

This block holds the two programmable thresholds used by a FIFO's flag logic: the almost-empty offset and the almost-full offset. Software-side logic programs them over a shared parallel bus whose width is a parameter (9, 18 or 36 bits). It also reads them back over that bus. An internal cycle pointer breaks each offset into one or more bus-sized chunks. The almost-empty register always comes first and the almost-full register follows it. Within each register the least significant chunk comes first.

A load strobe writes the bus word into the chunk the pointer selects and advances the pointer. A read strobe latches that chunk onto the read bus and advances the pointer. After the last chunk of the almost-full offset the pointer returns to the first almost-empty chunk. A parity-lane option keeps bit 8 of every 9-bit byte lane free of offset bits. Readback needs at least one idle cycle between two read strobes. A read strobe held over consecutive cycles is refused and flagged.

Both strobes are plain single-cycle controls with no back-pressure. Every load is taken in the cycle it is asserted. A read is taken unless the rules below refuse it, and refusal is reported only through the violation pulse.

Top module: `ofs_load_seq`

## Requirements
- R1: After reset the almost-empty offset equals parameter AE_DEF, the almost-full offset equals AF_DEF, the read bus is zero, the violation output is low, and the pointer is on the first almost-empty chunk.
- R2: The pointer visits every almost-empty chunk, low to high, and then every almost-full chunk, low to high. Loads and reads use this same order. A load to one register never changes the other.
- R3: Each chunk holds BPC = 8*(BUS_W/9) offset bits. Each register takes ceil(OFS_W/BPC) chunks, and chunk c carries offset bits c*BPC upward. This gives 6 cycles for 18-bit offsets on a 9-bit bus and 2 cycles on a 36-bit bus.
- R4: With PARITY_LANES=0, chunk bit j travels on bus bit j, and bus bits at or above BPC are ignored on load and zero on read.
- R5: With PARITY_LANES=1, chunk bit j travels on bus bit 9*(j/8)+(j%8). Bus bit 8 of every byte lane is ignored on load and zero on read.
- R6: Offset bits at or above OFS_W are discarded on load and read back as zero.
- R7: An accepted read places the selected chunk on the read bus in the cycle after the strobe and advances the pointer. The read bus then holds that value until the next accepted read.
- R8: A read strobe in the cycle directly after another read strobe is refused. The pointer and the read bus stay unchanged, and the violation output goes high for exactly the following cycle.
- R9: After the last almost-full chunk, the next load or accepted read targets the first almost-empty chunk again.
- R10: When load and read strobes arrive together, the load is performed and the read is dropped, so the read bus does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prg_ld | input | 1 | Load strobe: write bus chunk and advance pointer |
| prg_rd | input | 1 | Read strobe: latch selected chunk and advance pointer |
| bus_wdata | input | BUS_W | Load data bus |
| bus_rdata | output | BUS_W | Readback data bus, registered |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |
| rd_viol | output | 1 | One-cycle pulse for a refused back-to-back read |

## Verification
Every result is due one clock edge after its strobe. This covers an offset register updated by a load, the read bus after an accepted read, and the violation pulse after a refused read. The bench drives strobes on the falling edge and drops them at the next falling edge, then compares outputs at that point, half a cycle after the edge that acts on them. Reads are followed by one idle cycle so that only the deliberate back-to-back case triggers refusal. In that case the pulse is checked in the cycle after the second strobe, and again one cycle later, when it must have cleared.

// File: rtl/ofs_seq_pkg.sv
package ofs_seq_pkg;

  // Bus position of chunk bit j; with parity lanes, bit 8 of every byte lane is skipped.
  function automatic int lane_pos(input int j, input bit par_lanes);
    return par_lanes ? 9 * (j / 8) + (j % 8) : j;
  endfunction

  // Mask of bus bits that carry chunk bits.
  function automatic logic [63:0] lane_mask(input int bpc, input bit par_lanes);
    logic [63:0] m;
    m = '0;
    for (int j = 0; j < bpc; j++) m[lane_pos(j, par_lanes)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/ofs_lane_map.sv
module ofs_lane_map
  import ofs_seq_pkg::*;
#(
  parameter int BUS_W        = 9,
  parameter int BPC          = 8,
  parameter bit PARITY_LANES = 1'b0
) (
  input  logic [BUS_W-1:0] bus_in,
  output logic [BPC-1:0]   chunk_out,
  input  logic [BPC-1:0]   chunk_in,
  output logic [BUS_W-1:0] bus_out
);

  for (genvar j = 0; j < BPC; j++) begin : g_lane
    localparam int POS = lane_pos(j, PARITY_LANES);
    assign chunk_out[j] = bus_in[POS];
  end

  always_comb begin
    bus_out = '0;
    for (int j = 0; j < BPC; j++) bus_out[lane_pos(j, PARITY_LANES)] = chunk_in[j];
  end

endmodule

// File: rtl/ofs_seq_ptr.sv
module ofs_seq_ptr #(
  parameter int TOTAL = 6,
  localparam int PW   = (TOTAL > 2) ? $clog2(TOTAL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] ptr
);

  localparam logic [PW-1:0] LAST = PW'(TOTAL - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (adv)     ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  p_ptr_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < TOTAL);
  p_ptr_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    adv && ptr == LAST |=> ptr == '0);
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv && ptr != LAST |=> ptr == $past(ptr) + 1'b1);
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));

endmodule

// File: rtl/ofs_load_seq.sv
module ofs_load_seq
  import ofs_seq_pkg::*;
#(
  parameter int BUS_W        = 9,
  parameter int OFS_W        = 18,
  parameter bit PARITY_LANES = 1'b0,
  parameter int AE_DEF       = 5,
  parameter int AF_DEF       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prg_ld,
  input  logic             prg_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs,
  output logic             rd_viol
);

  localparam int BPC   = 8 * (BUS_W / 9);
  localparam int CPR   = (OFS_W + BPC - 1) / BPC;
  localparam int TOTAL = 2 * CPR;
  localparam int PW    = (TOTAL > 2) ? $clog2(TOTAL) : 1;
  localparam int EXT   = CPR * BPC;
  localparam logic [EXT-1:0]   VMASK = EXT'({OFS_W{1'b1}});
  localparam logic [BUS_W-1:0] LANES = BUS_W'(lane_mask(BPC, PARITY_LANES));

  logic [PW-1:0]    ptr, idx;
  logic             in_af, rd_prev, rd_acc, adv;
  int               shamt;
  logic [BPC-1:0]   wchunk, rchunk;
  logic [BUS_W-1:0] rbus;
  logic [EXT-1:0]   ae_q, af_q, sel_ext, wr_ext, src_ext;

  assign rd_acc = prg_rd && !rd_prev && !prg_ld;
  assign adv    = prg_ld || rd_acc;

  ofs_seq_ptr #(.TOTAL(TOTAL)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(adv), .ptr(ptr)
  );

  ofs_lane_map #(.BUS_W(BUS_W), .BPC(BPC), .PARITY_LANES(PARITY_LANES)) u_map (
    .bus_in(bus_wdata), .chunk_out(wchunk), .chunk_in(rchunk), .bus_out(rbus)
  );

  always_comb begin
    in_af   = ptr >= PW'(CPR);
    idx     = in_af ? ptr - PW'(CPR) : ptr;
    shamt   = int'(idx) * BPC;
    sel_ext = EXT'({BPC{1'b1}}) << shamt;
    wr_ext  = (EXT'(wchunk) << shamt) & sel_ext & VMASK;
    src_ext = in_af ? af_q : ae_q;
    rchunk  = BPC'(src_ext >> shamt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ae_q      <= EXT'(AE_DEF) & VMASK;
      af_q      <= EXT'(AF_DEF) & VMASK;
      rd_prev   <= 1'b0;
      rd_viol   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      rd_prev <= prg_rd;
      rd_viol <= prg_rd && rd_prev;
      if (prg_ld) begin
        if (in_af) af_q <= (af_q & ~sel_ext) | wr_ext;
        else       ae_q <= (ae_q & ~sel_ext) | wr_ext;
      end
      if (rd_acc) bus_rdata <= rbus;
    end
  end

  assign ae_ofs = ae_q[OFS_W-1:0];
  assign af_ofs = af_q[OFS_W-1:0];

  p_viol_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_viol |-> $past(prg_rd) && $past(prg_rd, 2));
  p_refused_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_viol |-> $stable(bus_rdata));
  p_collision_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prg_ld && prg_rd |=> $stable(bus_rdata));
  p_rdata_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~LANES) == '0);
  p_ae_untouched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prg_ld && in_af |=> $stable(ae_ofs));
  p_af_untouched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prg_ld && !in_af |=> $stable(af_ofs));

endmodule

// File: tb/ofs_load_seq_tb_top.sv
module ofs_load_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // A: 9-bit bus, 18-bit offsets, contiguous lanes
  logic a_ld = 0, a_rd = 0, a_viol;
  logic [8:0]  a_wd = '0, a_rdat;
  logic [17:0] a_ae, a_af;
  // B: 18-bit bus, 17-bit offsets, parity lanes
  logic b_ld = 0, b_rd = 0, b_viol;
  logic [17:0] b_wd = '0, b_rdat;
  logic [16:0] b_ae, b_af;
  // C: 36-bit bus, 10-bit offsets, contiguous lanes
  logic c_ld = 0, c_rd = 0, c_viol;
  logic [35:0] c_wd = '0, c_rdat;
  logic [9:0]  c_ae, c_af;

  ofs_load_seq dut_i (
    .clk(clk), .rst_n(rst_n), .prg_ld(a_ld), .prg_rd(a_rd), .bus_wdata(a_wd),
    .bus_rdata(a_rdat), .ae_ofs(a_ae), .af_ofs(a_af), .rd_viol(a_viol));

  ofs_load_seq #(.BUS_W(18), .OFS_W(17), .PARITY_LANES(1'b1), .AE_DEF(3), .AF_DEF(4)) dut2_i (
    .clk(clk), .rst_n(rst_n), .prg_ld(b_ld), .prg_rd(b_rd), .bus_wdata(b_wd),
    .bus_rdata(b_rdat), .ae_ofs(b_ae), .af_ofs(b_af), .rd_viol(b_viol));

  ofs_load_seq #(.BUS_W(36), .OFS_W(10), .AE_DEF(1), .AF_DEF(2)) dut3_i (
    .clk(clk), .rst_n(rst_n), .prg_ld(c_ld), .prg_rd(c_rd), .bus_wdata(c_wd),
    .bus_rdata(c_rdat), .ae_ofs(c_ae), .af_ofs(c_af), .rd_viol(c_viol));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One strobe cycle per call; inputs set on a falling edge, outputs compared one edge later.
  task automatic a_op(input logic ld, input logic rd, input logic [8:0] wd);
    a_ld = ld; a_rd = rd; a_wd = wd;
    @(negedge clk);
    a_ld = 0; a_rd = 0;
  endtask
  task automatic a_read(input string req, input logic [8:0] exp);
    a_op(0, 1, '0);
    chk(req, a_rdat, exp);
    @(negedge clk);
  endtask
  task automatic b_op(input logic ld, input logic rd, input logic [17:0] wd);
    b_ld = ld; b_rd = rd; b_wd = wd;
    @(negedge clk);
    b_ld = 0; b_rd = 0;
  endtask
  task automatic c_op(input logic ld, input logic rd, input logic [35:0] wd);
    c_ld = ld; c_rd = rd; c_wd = wd;
    @(negedge clk);
    c_ld = 0; c_rd = 0;
  endtask

  task automatic t_reset;
    chk("R1 ae default", a_ae, 18'd5);
    chk("R1 af default", a_af, 18'd9);
    chk("R1 rdata zero", a_rdat, 0);
    chk("R1 viol low", a_viol, 0);
    chk("R1 B ae default", b_ae, 17'd3);
    chk("R1 C af default", c_af, 10'd2);
  endtask

  task automatic t_load_a;
    a_op(1, 0, 9'h1C3);
    chk("R3 low chunk first", a_ae, 18'h000C3);
    a_op(1, 0, 9'h1A5);
    a_op(1, 0, 9'h1FE);
    chk("R6 R4 ae assembled", a_ae, 18'h2A5C3);
    chk("R2 af untouched", a_af, 18'd9);
    a_op(1, 0, 9'h07E);
    a_op(1, 0, 9'h03C);
    a_op(1, 0, 9'h001);
    chk("R2 af assembled", a_af, 18'h13C7E);
    chk("R2 ae kept", a_ae, 18'h2A5C3);
  endtask

  task automatic t_read_a;
    a_read("R7 read ae c0", 9'h0C3);
    a_read("R7 read ae c1", 9'h0A5);
    a_read("R6 read ae c2 high zero", 9'h002);
    a_read("R2 read af c0", 9'h07E);
    a_read("R2 read af c1", 9'h03C);
    a_read("R2 read af c2", 9'h001);
    a_read("R9 read wraps", 9'h0C3);
  endtask

  task automatic t_b2b;
    a_rd = 1;
    @(negedge clk);
    chk("R7 first read taken", a_rdat, 9'h0A5);
    chk("R8 no viol on first", a_viol, 0);
    @(negedge clk);
    a_rd = 0;
    chk("R8 viol pulse", a_viol, 1);
    chk("R8 rdata held", a_rdat, 9'h0A5);
    @(negedge clk);
    chk("R8 viol cleared", a_viol, 0);
    a_read("R8 pointer advanced once", 9'h002);
  endtask

  task automatic t_collision;
    a_op(1, 1, 9'h011);
    chk("R10 load done", a_af, 18'h13C11);
    chk("R10 rdata unchanged", a_rdat, 9'h002);
    @(negedge clk);
    a_read("R10 pointer moved once", 9'h03C);
    a_read("R9 last chunk", 9'h001);
  endtask

  task automatic t_parity_b;
    b_op(1, 0, 18'h24745);
    b_op(1, 0, 18'h00301);
    chk("R5 parity lanes ignored", b_ae, 17'h12345);
    b_op(1, 0, 18'h156CD);
    b_op(1, 0, 18'h00000);
    chk("R5 af via parity lanes", b_af, 17'h0ABCD);
    b_op(0, 1, '0);
    chk("R5 read parity zero", b_rdat, 18'h04645);
    @(negedge clk);
    b_op(0, 1, '0);
    chk("R5 read high chunk", b_rdat, 18'h00001);
    @(negedge clk);
    b_op(0, 1, '0);
    chk("R5 read af chunk", b_rdat, 18'h156CD);
    @(negedge clk);
  endtask

  task automatic t_wide_c;
    c_op(1, 0, 36'hF_FFFF_FE12);
    chk("R3 one cycle ae", c_ae, 10'h212);
    c_op(1, 0, 36'h0_0000_03FF);
    chk("R3 one cycle af", c_af, 10'h3FF);
    c_op(1, 0, 36'h0_0000_0005);
    chk("R9 two-cycle wrap", c_ae, 10'h005);
    chk("R9 af intact", c_af, 10'h3FF);
    c_op(0, 1, '0);
    chk("R4 wide read af", c_rdat, 36'h3FF);
    @(negedge clk);
    c_op(0, 1, '0);
    chk("R4 wide read ae", c_rdat, 36'h005);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_a();
    t_read_a();
    t_b2b();
    t_collision();
    t_parity_b();
    t_wide_c();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule